// File: doc/BRIEF.md
# Packet Locking Output Arbiter

This block joins four flit input channels onto one output channel so that a packet's flits reach the output without interruption. Each input carries a valid/ready handshake, a data word and a one-hot flit type of header, body or tail. A header waiting on an input raises that input's line in a request vector toward an external arbiter. The arbiter answers with a one-hot grant vector. Once its header has passed, the granted input owns the output until its tail flit has been handed over. Only then does it withdraw its request.

Each input has its own small ownership state machine. A shared merge stage routes the owning input's valid, type and data to the output, and returns the output's ready to that input alone. Inputs that lose keep their header presented and wait without transferring. After a tail transfer, the owner holds its request low for one cycle, so the arbiter can hand ownership to a waiting input. That handover happens no earlier than the cycle after the tail. The arbitration policy itself is not part of this block.

Top module: `pla_top`

## Requirements
- R1: An idle input presenting a valid header (type bit 0 set) drives its `arb_req` bit high in the same cycle.
- R2: A header is accepted (`in_ready` high for that input) only in a cycle where that input's `arb_gnt` bit is high.
- R3: After its header transfers, an input keeps `arb_req` high, and body flits (type bit 1) pass without any new grant cycle, until its tail transfers.
- R4: In the cycle after a tail flit (type bit 2) transfers, that input's `arb_req` and `in_ready` are both low, even if a new header is already waiting.
- R5: An input that is requesting but not granted sees `in_ready` low, and its flit does not appear at the output.
- R6: A body or tail flit on an input that owns nothing raises no request, is not accepted, and does not reach the output.
- R7: While an input owns the output, `out_valid`, `out_kind` and `out_data` equal that input's valid, type and data. With no owner, all three are zero.
- R8: While `out_ready` is low, no `in_ready` bit is high.
- R9: After reset, `arb_req`, `in_ready` and `out_valid` are all zero.
- R10: At most one `in_ready` bit is high in any cycle when the grant vector is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-input flit valid |
| in_kind | input | 12 | Per-input one-hot type, 3 bits per input (bit0 header, bit1 body, bit2 tail) |
| in_data | input | 64 | Per-input flit data, DATA_W bits per input |
| in_ready | output | 4 | Per-input accept |
| arb_req | output | 4 | Request vector to the external arbiter |
| arb_gnt | input | 4 | One-hot grant vector from the external arbiter |
| out_valid | output | 1 | Output flit valid |
| out_kind | output | 3 | Output flit type |
| out_data | output | 16 | Output flit data |
| out_ready | input | 1 | Output accept |

## Verification
The bench aims at four corners. The first is a tail followed at once by a fresh header on the same input. A design without the release cycle would keep its request high and lock out a waiting rival. The second is two headers arriving together. If the loser's ready leaked, its flits would be duplicated or interleaved into the winner's packet. The third is a stray body flit on an idle input. A design that treated any flit as a request would seize the output without a header. The last is output backpressure in the middle of a packet. Getting it wrong would drop a flit, or advance an input whose flit never left.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int KIND_W  = 3;
  localparam int K_HEAD  = 0;
  localparam int K_BODY  = 1;
  localparam int K_TAIL  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_GAP  = 2'd2
  } own_st_e;
endpackage

// File: rtl/pla_access_ctl.sv
module pla_access_ctl
  import pla_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic [KIND_W-1:0] flit_kind,
  input  logic              gnt,
  input  logic              ack,
  output logic              req,
  output logic              active
);
  own_st_e st_q, st_d;
  logic    st_en;
  logic    head_v, tail_v;

  always_comb begin
    head_v = flit_valid & flit_kind[K_HEAD];
    tail_v = flit_valid & flit_kind[K_TAIL];
    req    = (st_q == ST_OWN) | ((st_q == ST_IDLE) & head_v);
    active = gnt & req;
    st_d   = st_q;
    case (st_q)
      ST_IDLE: if (ack & head_v) st_d = ST_OWN;
      ST_OWN:  if (ack & tail_v) st_d = ST_GAP;
      ST_GAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  // R3: a granted header keeps the request up
  p_lock_after_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & head_v) |=> req);
  // R4: one quiet cycle after the tail
  p_release_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & tail_v & (st_q == ST_OWN)) |=> (!req && !ack));
  // R6: stray body/tail on an idle input is inert
  p_stray_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && flit_valid && !flit_kind[K_HEAD]) |-> (!req && !ack));
endmodule

// File: rtl/pla_merge.sv
module pla_merge
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 16
) (
  input  logic [N_IN-1:0]              sel,
  input  logic [N_IN-1:0]              valid,
  input  logic [N_IN-1:0][KIND_W-1:0]  kind,
  input  logic [N_IN-1:0][DATA_W-1:0]  data,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [KIND_W-1:0]            out_kind,
  output logic [DATA_W-1:0]            out_data,
  output logic [N_IN-1:0]              ack
);
  always_comb begin
    out_valid = 1'b0;
    out_kind  = '0;
    out_data  = '0;
    for (int i = 0; i < N_IN; i++) begin
      ack[i] = sel[i] & out_ready;
      if (sel[i]) begin
        out_valid = out_valid | valid[i];
        out_kind  = out_kind  | kind[i];
        out_data  = out_data  | data[i];
      end
    end
  end

  // R8: no ack escapes while the output stalls
  always_comb begin
    if (!out_ready) p_stall_no_ack_r8: assert (ack == '0);
  end
endmodule

// File: rtl/pla_top.sv
module pla_top
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN*KIND_W-1:0]   in_kind,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic [N_IN-1:0]          in_ready,
  output logic [N_IN-1:0]          arb_req,
  input  logic [N_IN-1:0]          arb_gnt,
  output logic                     out_valid,
  output logic [KIND_W-1:0]        out_kind,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     out_ready
);
  logic [N_IN-1:0]             sel;
  logic [N_IN-1:0]             ack;
  logic [N_IN-1:0][KIND_W-1:0] kind_a;
  logic [N_IN-1:0][DATA_W-1:0] data_a;

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    assign kind_a[g] = in_kind[g*KIND_W +: KIND_W];
    assign data_a[g] = in_data[g*DATA_W +: DATA_W];

    pla_access_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flit_valid (in_valid[g]),
      .flit_kind  (kind_a[g]),
      .gnt        (arb_gnt[g]),
      .ack        (ack[g]),
      .req        (arb_req[g]),
      .active     (sel[g])
    );
  end

  pla_merge #(.N_IN(N_IN), .DATA_W(DATA_W)) u_merge (
    .sel       (sel),
    .valid     (in_valid),
    .kind      (kind_a),
    .data      (data_a),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_data  (out_data),
    .ack       (ack)
  );

  assign in_ready = ack;

  // R10: single accepting input under a sane grant
  p_single_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_gnt) |-> $onehot0(in_ready));
  // R2: acceptance only under grant
  p_accept_needs_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~arb_gnt) == '0);
  // R7: output silent when nothing is selected
  p_idle_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/tb_pla_top.sv
module tb_pla_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int KW = 3;
  localparam logic [2:0] HEAD = 3'b001;
  localparam logic [2:0] BODY = 3'b010;
  localparam logic [2:0] TAIL = 3'b100;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    in_valid;
  logic [N*KW-1:0] in_kind;
  logic [N*W-1:0]  in_data;
  logic [N-1:0]    in_ready, arb_req, arb_gnt;
  logic            out_valid, out_ready;
  logic [KW-1:0]   out_kind;
  logic [W-1:0]    out_data;

  logic          v [N];
  logic [KW-1:0] kd [N];
  logic [W-1:0]  dt [N];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_valid[i]            = v[i];
      in_kind[i*KW +: KW]    = kd[i];
      in_data[i*W +: W]      = dt[i];
    end
  end

  // bench arbiter: holds grant while requested, else lowest index, registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arb_gnt <= '0;
    else if ((arb_gnt & arb_req) != '0) arb_gnt <= arb_gnt;
    else begin
      arb_gnt <= '0;
      for (int i = N-1; i >= 0; i--)
        if (arb_req[i]) arb_gnt <= 4'(1 << i);
    end
  end

  pla_top #(.N_IN(N), .DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_data(in_data), .in_ready(in_ready), .arb_req(arb_req),
    .arb_gnt(arb_gnt), .out_valid(out_valid), .out_kind(out_kind),
    .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one flit on ch, wait for acceptance, check output, return after the edge
  task automatic xfer(int ch, logic [2:0] k, logic [W-1:0] d);
    int waitc = 0;
    @(negedge clk);
    v[ch] = 1'b1; kd[ch] = k; dt[ch] = d;
    #1;
    while (!in_ready[ch] && waitc < 20) begin
      chk(out_valid == 1'b0 || out_data != d || arb_gnt[ch] == 1'b1,
          "R5 flit leaked before grant", out_data, 0);
      @(negedge clk); #1; waitc++;
    end
    chk(in_ready[ch] == 1'b1, "R2 flit accepted", in_ready, 4'(1 << ch));
    chk(out_valid && out_kind == k && out_data == d, "R7 output mirrors owner",
        {out_valid, out_kind, out_data}, {1'b1, k, d});
    chk(in_ready == 4'(1 << ch), "R10 single ready", in_ready, 4'(1 << ch));
    @(posedge clk); #1;
    v[ch] = 1'b0; kd[ch] = '0; dt[ch] = '0;
  endtask

  task automatic t_reset;
    #1;
    chk(arb_req == '0, "R9 req after reset", arb_req, 0);
    chk(in_ready == '0, "R9 ready after reset", in_ready, 0);
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_single;
    @(negedge clk);
    v[2] = 1; kd[2] = HEAD; dt[2] = 16'hA200; #1;
    chk(arb_req == 4'b0100, "R1 header raises request", arb_req, 4'b0100);
    chk(in_ready == '0, "R2 header held before grant", in_ready, 0);
    xfer(2, HEAD, 16'hA200);
    chk(arb_req[2] == 1'b1, "R3 request held after header", arb_req, 4'b0100);
    xfer(2, BODY, 16'hA201);
    // backpressure mid-packet
    @(negedge clk);
    out_ready = 0; v[2] = 1; kd[2] = BODY; dt[2] = 16'hA202; #1;
    chk(in_ready == '0, "R8 no ready under stall", in_ready, 0);
    chk(out_valid && out_data == 16'hA202, "R7 stalled output holds", out_data, 16'hA202);
    @(negedge clk); #1;
    chk(in_ready == '0 && arb_req[2], "R8 still stalled", in_ready, 0);
    out_ready = 1;
    xfer(2, BODY, 16'hA202);
    chk(arb_req[2] == 1'b1, "R3 bodies pass without re-arbitration", arb_req, 4'b0100);
    xfer(2, TAIL, 16'hA2FF);
    #1;
    chk(arb_req == '0, "R4 request dropped after tail", arb_req, 0);
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && out_data == '0, "R7 quiet output with no owner", out_data, 0);
  endtask

  task automatic t_contend;
    @(negedge clk);
    v[3] = 1; kd[3] = HEAD; dt[3] = 16'hD300;
    v[0] = 1; kd[0] = HEAD; dt[0] = 16'hD000; #1;
    chk(arb_req == 4'b1001, "R1 both requests raised", arb_req, 4'b1001);
    xfer(0, HEAD, 16'hD000);
    v[3] = 1; kd[3] = HEAD; dt[3] = 16'hD300;
    chk(in_ready[3] == 1'b0 && arb_req[3], "R5 loser waits", in_ready, 0);
    xfer(0, BODY, 16'hD001);
    v[3] = 1; kd[3] = HEAD; dt[3] = 16'hD300;
    #1;
    chk(in_ready[3] == 1'b0, "R5 loser still blocked", in_ready, 0);
    xfer(0, TAIL, 16'hD0FF);
    // new header on ch0 right after its tail
    v[0] = 1; kd[0] = HEAD; dt[0] = 16'hD010;
    v[3] = 1; kd[3] = HEAD; dt[3] = 16'hD300;
    #1;
    chk(arb_req[0] == 1'b0, "R4 release cycle hides new header", arb_req, 4'b1000);
    chk(in_ready == '0, "R4 no accept in release cycle", in_ready, 0);
    xfer(3, HEAD, 16'hD300);
    chk(in_ready[0] == 1'b0 && arb_req[0], "R5 previous owner now waits", in_ready, 0);
    xfer(3, TAIL, 16'hD3FF);
    xfer(0, HEAD, 16'hD010);
    xfer(0, TAIL, 16'hD0EE);
  endtask

  task automatic t_stray;
    @(negedge clk);
    v[1] = 1; kd[1] = BODY; dt[1] = 16'h5111;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(arb_req[1] == 1'b0 && in_ready[1] == 1'b0, "R6 stray body ignored",
          {arb_req, in_ready}, 0);
      chk(out_valid == 1'b0, "R6 stray body not forwarded", out_valid, 0);
      @(negedge clk);
    end
    kd[1] = TAIL; #1;
    chk(arb_req[1] == 1'b0 && out_valid == 1'b0, "R6 stray tail ignored", arb_req, 0);
    v[1] = 0; kd[1] = '0; dt[1] = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin v[i] = 0; kd[i] = '0; dt[i] = '0; end
    out_ready = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_stray();
    t_contend();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule